// File: doc/BRIEF.md
# Full-Scan Vector Sequencer

This block applies stored combinational test vectors to a circuit whose state flops are stitched into several scan chains of possibly different lengths. For every vector it shifts the present state into all chains at once with the test-control line low. It then raises test control for exactly one clock, drives the vector's primary-input bits, and compares the circuit's primary outputs against the stored expectation. The captured next state leaves the chains while the following vector is shifted in. After the last capture, one extra shift pass empties the chains.

Chains shorter than the longest one are fed leading filler bits, so that every chain receives its last real bit on the final shift cycle. Outgoing bits that belong to filler positions are not compared. Vectors are written into a small internal store while the block is idle. The block then runs from a start pulse to a one-cycle done pulse and reports a sticky fail flag together with the index of the first vector whose response was wrong.

Top module: `scan_test_seq`

## Requirements
- R1: A start pulse is accepted only while idle and with a vector count between 1 and DEPTH. An accepted start makes busy_o high from the next cycle. A start with any other count, or a start while busy, has no effect.
- R2: A write to the vector store takes effect only while idle. A write presented while busy is dropped. Each vector holds a present-state field with chain c at bits [c*MAX_LEN +: MAX_LEN], primary-input bits, an expected next-state field in the same layout, and expected primary-output bits.
- R3: Each vector takes MAX_LEN shift cycles with tc_o low, followed by one capture cycle with tc_o high. A run of n vectors is followed by a final MAX_LEN-cycle shift pass, so it lasts (n+1)*MAX_LEN + n cycles.
- R4: Let j count from 0 to MAX_LEN-1 within a shift pass. A chain of length L drives 0 on scan-in while j < MAX_LEN-L, and drives present-state bit MAX_LEN-1-j otherwise. Scan-in is 0 during capture cycles and during the final shift pass.
- R5: pi_o carries the current vector's primary-input bits during the capture cycle and is 0 in every other cycle.
- R6: During a capture cycle, po_i is compared with the vector's expected primary outputs.
- R7: In the shift pass that follows the capture of vector v, a chain of length L compares scan_out_i with expected next-state bit L-1-j of vector v while j < L. Positions j >= L are masked, as are all expected bits at index L and above.
- R8: fail_o is cleared by an accepted start and stays high once set. fail_idx_o holds the index of the first vector found wrong and is not changed by later mismatches in the same run.
- R9: done_o is high for exactly one cycle, immediately after the last shift cycle of a run. From that cycle on, busy_o is low.
- R10: While idle, tc_o, scan_in_o and pi_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches a run |
| n_vec_i | input | $clog2(DEPTH)+1 | Number of vectors for the run |
| vec_we_i | input | 1 | Vector store write enable |
| vec_addr_i | input | $clog2(DEPTH) | Vector store write address |
| vec_ps_i | input | N_CHAINS*MAX_LEN | Present-state bits, one field per chain |
| vec_pi_i | input | N_PI | Primary-input bits |
| vec_ens_i | input | N_CHAINS*MAX_LEN | Expected next-state bits, one field per chain |
| vec_epo_i | input | N_PO | Expected primary-output bits |
| tc_o | output | 1 | Test control: 0 shift, 1 capture |
| scan_in_o | output | N_CHAINS | Per-chain scan-in bit |
| pi_o | output | N_PI | Primary inputs to the circuit |
| scan_out_i | input | N_CHAINS | Per-chain scan-out bit |
| po_i | input | N_PO | Primary outputs of the circuit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_idx_o | output | $clog2(DEPTH) | Index of the first failing vector |

## Verification
In every shift pass between two captures, the unload of vector v and the load of vector v+1 share the same cycles. A stale or wrong read address therefore corrupts either the bits leaving the chains or the bits entering them. The bench attaches a behavioural model of the scanned circuit and records, for each cycle, the test control, scan-in and primary inputs it expects. It checks those values every clock. It also plants wrong expected bits in real positions and in filler positions, including the last vector, which is unloaded with no load alongside it. It then judges the fail flag and the first-failing index that come back.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_CAPT  = 2'd2
  } phase_e;
endpackage

// File: rtl/scan_vec_mem.sv
module scan_vec_mem #(
  parameter int DEPTH = 8,
  parameter int PS_W  = 15,
  parameter int PI_W  = 4,
  parameter int PO_W  = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [PS_W-1:0] wps_i,
  input  logic [PI_W-1:0] wpi_i,
  input  logic [PS_W-1:0] wens_i,
  input  logic [PO_W-1:0] wepo_i,
  input  logic [AW-1:0]   raddr_a_i,
  output logic [PS_W-1:0] ps_a_o,
  output logic [PI_W-1:0] pi_a_o,
  output logic [PO_W-1:0] epo_a_o,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [PS_W-1:0] ens_b_o
);
  logic [PS_W-1:0] ps_q  [DEPTH];
  logic [PI_W-1:0] pi_q  [DEPTH];
  logic [PS_W-1:0] ens_q [DEPTH];
  logic [PO_W-1:0] epo_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ps_q[i]  <= '0;
        pi_q[i]  <= '0;
        ens_q[i] <= '0;
        epo_q[i] <= '0;
      end
    end else if (we_i) begin
      ps_q[waddr_i]  <= wps_i;
      pi_q[waddr_i]  <= wpi_i;
      ens_q[waddr_i] <= wens_i;
      epo_q[waddr_i] <= wepo_i;
    end
  end

  assign ps_a_o  = ps_q[raddr_a_i];
  assign pi_a_o  = pi_q[raddr_a_i];
  assign epo_a_o = epo_q[raddr_a_i];
  assign ens_b_o = ens_q[raddr_b_i];
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int MAX_LEN = 5,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int BW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] n_vec_i,
  output phase_e        phase_o,
  output logic [BW-1:0] bit_cnt_o,
  output logic [CW-1:0] vec_cnt_o,
  output logic          load_v_o,
  output logic          unload_v_o,
  output logic          start_acc_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [BW-1:0] bit_q;
  logic [CW-1:0] vec_q, n_q;
  logic          done_q;
  logic          last_bit;

  assign last_bit    = (bit_q == BW'(MAX_LEN - 1));
  assign start_acc_o = (phase_q == PH_IDLE) && start_i &&
                       (n_vec_i != '0) && (n_vec_i <= CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      vec_q   <= '0;
      n_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_acc_o) begin
          phase_q <= PH_SHIFT;
          bit_q   <= '0;
          vec_q   <= '0;
          n_q     <= n_vec_i;
        end
        PH_SHIFT: begin
          if (last_bit) begin
            bit_q <= '0;
            if (vec_q < n_q) phase_q <= PH_CAPT;
            else begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        PH_CAPT: begin
          vec_q   <= vec_q + CW'(1);
          phase_q <= PH_SHIFT;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign bit_cnt_o  = bit_q;
  assign vec_cnt_o  = vec_q;
  assign load_v_o   = (phase_q == PH_SHIFT) && (vec_q < n_q);
  assign unload_v_o = (phase_q == PH_SHIFT) && (vec_q != '0);
  assign done_o     = done_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_acc_o |=> (phase_q == PH_SHIFT) && (bit_q == '0)); // R1
  AST_CAPT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CAPT) |=> (phase_q == PH_SHIFT)); // R3
  AST_SHIFT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SHIFT) && !last_bit |=> (phase_q == PH_SHIFT)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q && (phase_q == PH_IDLE)); // R9
endmodule

// File: rtl/scan_chain_lane.sv
module scan_chain_lane #(
  parameter int MAX_LEN = 5,
  parameter int LEN     = 5,
  localparam int BW     = $clog2(MAX_LEN + 1),
  localparam int PAD    = MAX_LEN - LEN
) (
  input  logic [BW-1:0]      bit_cnt_i,
  input  logic               load_v_i,
  input  logic               unload_v_i,
  input  logic [MAX_LEN-1:0] ps_i,
  input  logic [MAX_LEN-1:0] ens_i,
  input  logic               scan_out_i,
  output logic               scan_in_o,
  output logic               mismatch_o
);
  logic [BW-1:0] ld_pos, ul_pos;
  logic          ld_real, ul_real;

  assign ld_pos  = BW'(MAX_LEN - 1) - bit_cnt_i;
  assign ul_pos  = BW'(LEN - 1) - bit_cnt_i;
  assign ld_real = int'(bit_cnt_i) >= PAD;
  assign ul_real = int'(bit_cnt_i) < LEN;

  // leading filler bits are driven as 0
  assign scan_in_o  = (load_v_i && ld_real) ? ps_i[ld_pos] : 1'b0;
  assign mismatch_o = unload_v_i && ul_real && (scan_out_i != ens_i[ul_pos]);
endmodule

// File: rtl/scan_resp_check.sv
module scan_resp_check #(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_acc_i,
  input  logic          po_bad_i,
  input  logic [AW-1:0] po_idx_i,
  input  logic          ns_bad_i,
  input  logic [AW-1:0] ns_idx_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_idx_o
);
  logic          fail_q;
  logic [AW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_acc_i) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
    end else if (!fail_q) begin
      if (po_bad_i) begin
        fail_q <= 1'b1;
        idx_q  <= po_idx_i;
      end else if (ns_bad_i) begin
        fail_q <= 1'b1;
        idx_q  <= ns_idx_i;
      end
    end
  end

  assign fail_o     = fail_q;
  assign fail_idx_o = idx_q;

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !start_acc_i |=> fail_q); // R8
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !start_acc_i |=> $stable(idx_q)); // R8
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
#(
  parameter int N_CHAINS                   = 3,
  parameter int MAX_LEN                    = 5,
  parameter logic [N_CHAINS*8-1:0] CHAIN_LENS = {8'd4, 8'd3, 8'd5},
  parameter int N_PI                       = 4,
  parameter int N_PO                       = 3,
  parameter int DEPTH                      = 8,
  localparam int AW                        = $clog2(DEPTH),
  localparam int CW                        = AW + 1,
  localparam int SW                        = N_CHAINS * MAX_LEN
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CW-1:0]       n_vec_i,
  input  logic                vec_we_i,
  input  logic [AW-1:0]       vec_addr_i,
  input  logic [SW-1:0]       vec_ps_i,
  input  logic [N_PI-1:0]     vec_pi_i,
  input  logic [SW-1:0]       vec_ens_i,
  input  logic [N_PO-1:0]     vec_epo_i,
  output logic                tc_o,
  output logic [N_CHAINS-1:0] scan_in_o,
  output logic [N_PI-1:0]     pi_o,
  input  logic [N_CHAINS-1:0] scan_out_i,
  input  logic [N_PO-1:0]     po_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [AW-1:0]       fail_idx_o
);
  localparam int BW = $clog2(MAX_LEN + 1);

  phase_e              phase;
  logic [BW-1:0]       bit_cnt;
  logic [CW-1:0]       vec_cnt;
  logic                load_v, unload_v, start_acc;
  logic [AW-1:0]       rd_a, rd_b;
  logic [SW-1:0]       cur_ps, prev_ens;
  logic [N_PI-1:0]     cur_pi;
  logic [N_PO-1:0]     cur_epo;
  logic [N_CHAINS-1:0] lane_bad;
  logic                capt, po_bad, mem_we;

  scan_seq_ctrl #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .n_vec_i     (n_vec_i),
    .phase_o     (phase),
    .bit_cnt_o   (bit_cnt),
    .vec_cnt_o   (vec_cnt),
    .load_v_o    (load_v),
    .unload_v_o  (unload_v),
    .start_acc_o (start_acc),
    .done_o      (done_o)
  );

  // port A: vector being loaded/captured; port B: vector being unloaded
  assign rd_a   = vec_cnt[AW-1:0];
  assign rd_b   = vec_cnt[AW-1:0] - AW'(1);
  assign mem_we = vec_we_i && (phase == PH_IDLE);

  scan_vec_mem #(.DEPTH(DEPTH), .PS_W(SW), .PI_W(N_PI), .PO_W(N_PO)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (mem_we),
    .waddr_i   (vec_addr_i),
    .wps_i     (vec_ps_i),
    .wpi_i     (vec_pi_i),
    .wens_i    (vec_ens_i),
    .wepo_i    (vec_epo_i),
    .raddr_a_i (rd_a),
    .ps_a_o    (cur_ps),
    .pi_a_o    (cur_pi),
    .epo_a_o   (cur_epo),
    .raddr_b_i (rd_b),
    .ens_b_o   (prev_ens)
  );

  for (genvar c = 0; c < N_CHAINS; c++) begin : g_lane
    scan_chain_lane #(
      .MAX_LEN (MAX_LEN),
      .LEN     (int'(CHAIN_LENS[c*8 +: 8]))
    ) u_lane (
      .bit_cnt_i  (bit_cnt),
      .load_v_i   (load_v),
      .unload_v_i (unload_v),
      .ps_i       (cur_ps[c*MAX_LEN +: MAX_LEN]),
      .ens_i      (prev_ens[c*MAX_LEN +: MAX_LEN]),
      .scan_out_i (scan_out_i[c]),
      .scan_in_o  (scan_in_o[c]),
      .mismatch_o (lane_bad[c])
    );
  end

  assign capt   = (phase == PH_CAPT);
  assign tc_o   = capt;
  assign pi_o   = capt ? cur_pi : '0;
  assign po_bad = capt && (po_i != cur_epo);
  assign busy_o = (phase != PH_IDLE);

  scan_resp_check #(.AW(AW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_acc_i (start_acc),
    .po_bad_i    (po_bad),
    .po_idx_i    (rd_a),
    .ns_bad_i    (|lane_bad),
    .ns_idx_i    (rd_b),
    .fail_o      (fail_o),
    .fail_idx_o  (fail_idx_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tc_o && (scan_in_o == '0) && (pi_o == '0)); // R10
  AST_NO_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && vec_we_i |=> $stable(cur_epo) || (phase != $past(phase)) ||
                           (vec_cnt != $past(vec_cnt))); // R2
endmodule

// File: tb/scan_test_seq_test.sv
`timescale 1ns/1ps
module scan_test_seq_test;
  localparam int NC = 3, M = 5, NPI = 4, NPO = 3, DEPTH = 8;
  localparam int LEN [3] = '{5, 3, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start, we, tc, busy, done, fail;
  logic [3:0] n_vec;
  logic [2:0] addr, fail_idx;
  logic [14:0] w_ps, w_ens;
  logic [3:0] w_pi, pi;
  logic [2:0] w_epo, si, so, po;

  scan_test_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_vec_i(n_vec),
    .vec_we_i(we), .vec_addr_i(addr), .vec_ps_i(w_ps), .vec_pi_i(w_pi),
    .vec_ens_i(w_ens), .vec_epo_i(w_epo), .tc_o(tc), .scan_in_o(si),
    .pi_o(pi), .scan_out_i(so), .po_i(po), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_idx_o(fail_idx)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  function automatic logic [14:0] mask_s(logic [14:0] s);
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < M; k++) if (k >= LEN[c]) s[c*M+k] = 1'b0;
    return s;
  endfunction

  function automatic logic [14:0] f_ns(logic [14:0] s, logic [3:0] p);
    logic [14:0] r = '0;
    for (int c = 0; c < NC; c++) begin
      int nc = (c + 1) % NC;
      for (int k = 0; k < LEN[c]; k++)
        r[c*M+k] = s[nc*M + (k % LEN[nc])] ^ p[(k+c) % NPI] ^
                   s[c*M + ((k+1) % LEN[c])] ^ (k == 0);
    end
    return r;
  endfunction

  function automatic logic [2:0] f_po(logic [14:0] s, logic [3:0] p);
    logic [2:0] r;
    for (int i = 0; i < NPO; i++) r[i] = (^s[i*M +: M]) ^ p[i] ^ p[3];
    return r;
  endfunction

  function automatic logic [14:0] f_shift(logic [14:0] s, logic [2:0] in);
    logic [14:0] r = s;
    for (int c = 0; c < NC; c++) begin
      for (int k = 1; k < LEN[c]; k++) r[c*M+k] = s[c*M+k-1];
      r[c*M] = in[c];
    end
    return r;
  endfunction

  // behavioural model of the scanned circuit
  logic [14:0] cs;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cs <= '0;
    else if (tc) cs <= f_ns(cs, pi);
    else cs <= f_shift(cs, si);

  always_comb begin
    for (int c = 0; c < NC; c++) so[c] = cs[c*M + LEN[c] - 1];
    po = f_po(cs, pi);
  end

  logic [14:0] b_ps [DEPTH], b_ens [DEPTH];
  logic [3:0]  b_pi [DEPTH];
  logic [2:0]  b_epo [DEPTH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [14:0] ps, input logic [3:0] p,
                    input logic [14:0] ens, input logic [2:0] epo);
    @(negedge clk);
    we = 1'b1; addr = 3'(a); w_ps = ps; w_pi = p; w_ens = ens; w_epo = epo;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic gen(input int v, input int seed);
    logic [14:0] s = mask_s(15'(v*4931 + seed*173) ^ 15'h5a3c);
    logic [3:0]  p = 4'(v*7 + seed*3 + 1);
    b_ps[v] = s; b_pi[v] = p; b_ens[v] = f_ns(s, p); b_epo[v] = f_po(s, p);
    wr(v, s, p, b_ens[v], b_epo[v]);
  endtask

  task automatic run(input int n, input bit exp_fail, input int exp_idx, input bit inject);
    logic [7:0] q[$];
    int i = 0;
    for (int v = 0; v <= n; v++) begin
      for (int j = 0; j < M; j++) begin
        logic [2:0] e_si = '0;
        for (int c = 0; c < NC; c++)
          if (v < n && j >= M - LEN[c]) e_si[c] = b_ps[v][c*M + M-1-j];
        q.push_back({1'b0, e_si, 4'b0});
      end
      if (v < n) q.push_back({1'b1, 3'b0, b_pi[v]});
    end
    @(negedge clk);
    n_vec = 4'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q.size() > 0) begin
      logic [7:0] e = q.pop_front();
      // R3/R4/R5: busy, no done, expected tc/scan-in/pi every cycle
      chk("R3/R4/R5 cycle", {22'b0, busy, done, tc, si, pi}, {22'b0, 2'b10, e});
      if (inject && i == 3) begin
        start = 1'b1; n_vec = 4'd1;              // R1: ignored while busy
        we = 1'b1; addr = 3'd0; w_ps = 15'h7fff; // R2: ignored while busy
        w_pi = 4'hf; w_ens = 15'h7fff; w_epo = 3'h7;
      end else if (inject && i == 4) begin
        start = 1'b0; we = 1'b0;
      end
      i++;
      @(negedge clk);
    end
    chk("R9 done pulse", {30'b0, done, busy}, {30'b0, 2'b10});
    chk("R8 fail flag", {31'b0, fail}, {31'b0, exp_fail});
    if (exp_fail) chk("R8 R6 R7 fail index", {29'b0, fail_idx}, 32'(exp_idx));
    @(negedge clk);
    chk("R9 done single", {31'b0, done}, 32'b0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    start = 0; we = 0; n_vec = 0; addr = 0;
    w_ps = 0; w_pi = 0; w_ens = 0; w_epo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset outputs", {24'b0, tc, si, pi}, 32'b0);
    chk("R9 R8 reset flags", {29'b0, busy, done, fail}, 32'b0);

    for (int v = 0; v < DEPTH; v++) gen(v, 1);

    // R1: counts 0 and DEPTH+1 rejected
    @(negedge clk); n_vec = 4'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 zero count", {31'b0, busy}, 32'b0);
    n_vec = 4'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R1 over count", {31'b0, busy}, 32'b0);

    run(4, 0, 0, 0);
    run(8, 0, 0, 1);
    run(1, 0, 0, 0); // R2: vector 0 unchanged after busy write

    // R7 R8: two bad next-state expectations, first one reported
    wr(1, b_ps[1], b_pi[1], b_ens[1] ^ 15'h0020, b_epo[1]);
    wr(3, b_ps[3], b_pi[3], b_ens[3] ^ 15'h0004, b_epo[3]);
    run(4, 1, 1, 0);
    wr(1, b_ps[1], b_pi[1], b_ens[1], b_epo[1]);
    wr(3, b_ps[3], b_pi[3], b_ens[3], b_epo[3]);

    // R7: last vector, checked in the final unload
    wr(2, b_ps[2], b_pi[2], b_ens[2] ^ 15'h2000, b_epo[2]);
    run(3, 1, 2, 0);
    wr(2, b_ps[2], b_pi[2], b_ens[2], b_epo[2]);

    // R6: wrong primary-output expectation
    wr(0, b_ps[0], b_pi[0], b_ens[0], b_epo[0] ^ 3'b010);
    run(2, 1, 0, 0);
    wr(0, b_ps[0], b_pi[0], b_ens[0], b_epo[0]);

    // R4 R7: filler positions ignored on load and on compare
    wr(0, b_ps[0] ^ 15'h4300, b_pi[0], b_ens[0] ^ 15'h4300, b_epo[0]);
    run(1, 0, 0, 0);
    wr(0, b_ps[0], b_pi[0], b_ens[0], b_epo[0]);

    // R8: flag cleared by the next start
    run(8, 0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule